// File: doc/BRIEF.md
# Shared Unit Ownership Arbiter with Freeze

This block decides which of three engines owns one shared scaling unit. Two decode engines (the even and odd member of a pair) and one enhancement engine each present a lock request. When the unit is free, the highest-priority requester is granted. The owner keeps the unit until it drops its request. Each engine can see from its usage output whether it is the current owner.

Any engine may raise a forced-lock input ahead of its own reset. This freezes the ownership state. A locked unit stays with its owner, and its release is held off. A free unit stays free and refuses every new lock request. The freeze is confirmed to each requesting engine on a per-engine acknowledge output, which follows its forced-lock input with one cycle of delay. A reset input dedicated to the unit clears ownership whatever else is happening. Software reads the usage output to decide whether the unit must be reset together with the engine.

Top module: `shared_lock_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, `in_use` and `lock_ack` become all zero after that edge.
- R2: With the unit free, no forced lock and no unit reset, a lock request is granted at the next edge, and the requester's `in_use` bit reads 1 after it.
- R3: When several engines request a free unit at the same edge, bit 0 (even decode engine) wins over bit 1 (odd decode engine), which wins over bit 2 (enhancement engine).
- R4: While the owner keeps its request high, the requests of other engines have no effect on `in_use`.
- R5: When the owner drops its request, with no forced lock, the unit becomes free at that edge. A different waiting requester is granted at the following edge.
- R6: While any `force_lock` bit is high and the unit is locked, the owner keeps the unit even if it drops its request. The release takes effect at the first edge with no forced lock.
- R7: While any `force_lock` bit is high and the unit is free, every lock request is ignored and `in_use` stays zero.
- R8: `lock_ack[i]` equals the value that `force_lock[i]` had at the previous clock edge. It rises one cycle after forced lock is sampled and falls one cycle after it clears.
- R9: `unit_rst` high at an edge frees the unit, even while forced lock is high. It does not change `lock_ack`.
- R10: `in_use` has at most one bit set, and bit i is set only while the unit is locked to engine i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| unit_rst | input | 1 | Synchronous reset of the shared unit's ownership only |
| lock_req | input | 3 | Per-engine lock request; bit 0 even decode, bit 1 odd decode, bit 2 enhancement |
| force_lock | input | 3 | Per-engine forced-lock (freeze) request |
| lock_ack | output | 3 | Per-engine acknowledge that ownership is frozen |
| in_use | output | 3 | Per-engine flag: unit currently locked to this engine |

## Verification
The assertions assume that all inputs are synchronous and settled at each rising edge. They also assume that `unit_rst` is the only thing allowed to override a freeze, so the stability checks are gated off in the cycles where it is high. The stimulus changes inputs only at the falling edge. It draws requests and freezes at random, with forced lock and unit reset kept rare so that grants, releases and frozen periods all occur. Directed steps cover the priority order, a release held off by a freeze, and a unit reset during a freeze.

// File: rtl/sla_pkg.sv
package sla_pkg;
    localparam int ENG_N = 3;
    localparam int IDX_W = (ENG_N > 1) ? $clog2(ENG_N) : 1;

    typedef logic [ENG_N-1:0] eng_vec_t;
    typedef logic [IDX_W-1:0] eng_idx_t;

    typedef struct packed {
        logic     held;
        eng_idx_t who;
    } own_t;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_TAKE = 2'd1,
        ACT_DROP = 2'd2,
        ACT_WIPE = 2'd3
    } own_act_e;

    localparam own_t OWN_FREE = '{held: 1'b0, who: '0};

    function automatic own_act_e choose_act(
        input logic     wipe,
        input logic     frozen,
        input own_t     cur,
        input eng_vec_t req,
        input logic     any_req
    );
        if (wipe)
            return ACT_WIPE;
        if (frozen)
            return ACT_KEEP;
        if (cur.held)
            return req[cur.who] ? ACT_KEEP : ACT_DROP;
        return any_req ? ACT_TAKE : ACT_KEEP;
    endfunction
endpackage

// File: rtl/sla_prio_pick.sv
module sla_prio_pick
    import sla_pkg::*;
(
    input  eng_vec_t req,
    output logic     any,
    output eng_idx_t idx
);
    logic [ENG_N:0] seen;
    eng_vec_t       first;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < ENG_N; i++) begin : g_chain
        assign first[i]    = req[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | req[i];
    end

    assign any = seen[ENG_N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENG_N; i++) begin
            if (first[i])
                idx = eng_idx_t'(i);
        end
    end
endmodule

// File: rtl/sla_owner_reg.sv
module sla_owner_reg
    import sla_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  own_act_e act,
    input  eng_idx_t take_idx,
    output own_t     own
);
    always_ff @(posedge clk) begin
        if (rst) begin
            own <= OWN_FREE;
        end else begin
            case (act)
                ACT_TAKE: own <= '{held: 1'b1, who: take_idx};
                ACT_DROP: own <= OWN_FREE;
                ACT_WIPE: own <= OWN_FREE;
                default:  own <= own;
            endcase
        end
    end

    assert_take_only_free_R2: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_TAKE) |-> !own.held);

    assert_take_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_TAKE) |=> (own.held && own.who == $past(take_idx)));

    assert_wipe_frees_R9: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_WIPE) |=> !own.held);

    assert_owner_range_R10: assert property (@(posedge clk) disable iff (rst)
        own.held |-> (int'(own.who) < ENG_N));
endmodule

// File: rtl/sla_ack_bank.sv
module sla_ack_bank
    import sla_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  eng_vec_t force_vec,
    output eng_vec_t ack
);
    for (genvar i = 0; i < ENG_N; i++) begin : g_ack
        always_ff @(posedge clk) begin
            if (rst)
                ack[i] <= 1'b0;
            else
                ack[i] <= force_vec[i];
        end

        assert_ack_rise_R8: assert property (@(posedge clk) disable iff (rst)
            force_vec[i] |=> ack[i]);

        assert_ack_fall_R8: assert property (@(posedge clk) disable iff (rst)
            !force_vec[i] |=> !ack[i]);
    end
endmodule

// File: rtl/shared_lock_arbiter.sv
module shared_lock_arbiter
    import sla_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       unit_rst,
    input  logic [2:0] lock_req,
    input  logic [2:0] force_lock,
    output logic [2:0] lock_ack,
    output logic [2:0] in_use
);
    own_t     own;
    own_act_e act;
    logic     any_req;
    eng_idx_t pick_idx;
    logic     frozen;

    assign frozen = |force_lock;

    sla_prio_pick u_pick (
        .req (lock_req),
        .any (any_req),
        .idx (pick_idx)
    );

    always_comb begin
        act = choose_act(unit_rst, frozen, own, lock_req, any_req);
    end

    sla_owner_reg u_owner (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .take_idx (pick_idx),
        .own      (own)
    );

    sla_ack_bank u_ack (
        .clk       (clk),
        .rst       (rst),
        .force_vec (force_lock),
        .ack       (lock_ack)
    );

    for (genvar i = 0; i < ENG_N; i++) begin : g_use
        assign in_use[i] = own.held && (own.who == eng_idx_t'(i));
    end

    assert_use_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_use));

    assert_owner_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (|(in_use & lock_req)) && !unit_rst |=> $stable(in_use));

    assert_freeze_locked_R6: assert property (@(posedge clk) disable iff (rst)
        frozen && !unit_rst |=> $stable(in_use));

    assert_freeze_free_R7: assert property (@(posedge clk) disable iff (rst)
        frozen && !unit_rst && (in_use == 3'b000) |=> (in_use == 3'b000));

    assert_top_prio_R3: assert property (@(posedge clk) disable iff (rst)
        !frozen && !unit_rst && (in_use == 3'b000) && lock_req[0] |=> in_use[0]);

    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        !frozen && !unit_rst && (|in_use) && !(|(in_use & lock_req)) |=> (in_use == 3'b000));

    assert_unit_reset_R9: assert property (@(posedge clk) disable iff (rst)
        unit_rst |=> (in_use == 3'b000));
endmodule

// File: tb/tb_shared_lock_arbiter.sv
`timescale 1ns/1ps
module tb_shared_lock_arbiter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       unit_rst = 1'b0;
    logic [2:0] lock_req = 3'b000;
    logic [2:0] force_lock = 3'b000;
    logic [2:0] lock_ack;
    logic [2:0] in_use;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit         m_held = 1'b0;
    int         m_who = 0;
    logic [2:0] m_ack = 3'b000;

    always #10 clk = ~clk;

    shared_lock_arbiter dut (
        .clk(clk), .rst(rst), .unit_rst(unit_rst),
        .lock_req(lock_req), .force_lock(force_lock),
        .lock_ack(lock_ack), .in_use(in_use)
    );

    function automatic logic [2:0] use_of(bit h, int w);
        return h ? (3'b001 << w) : 3'b000;
    endfunction

    function automatic int first_req(logic [2:0] r);
        for (int i = 0; i < 3; i++) if (r[i]) return i;
        return -1;
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_held = 1'b0; m_ack = 3'b000;
        end else begin
            if (unit_rst) m_held = 1'b0;
            else if (|force_lock) begin end
            else if (m_held) begin
                if (!lock_req[m_who]) m_held = 1'b0;
            end else if (first_req(lock_req) >= 0) begin
                m_held = 1'b1; m_who = first_req(lock_req);
            end
            m_ack = force_lock;
        end
    endtask

    task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(logic [2:0] r, logic [2:0] f, logic u);
        lock_req = r; force_lock = f; unit_rst = u;
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    initial begin
        #(20 * 10000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        step(3'b000, 3'b000, 1'b0);
        step(3'b000, 3'b000, 1'b0);
        chk("R1 in_use after reset", in_use, 3'b000);
        chk("R1 lock_ack after reset", lock_ack, 3'b000);
        rst = 1'b0;

        step(3'b110, 3'b000, 1'b0);
        chk("R2/R3 grant odd decode over enhancement", in_use, 3'b010);
        step(3'b111, 3'b000, 1'b0);
        chk("R4 owner keeps unit", in_use, 3'b010);
        step(3'b101, 3'b000, 1'b0);
        chk("R5 release frees unit", in_use, 3'b000);
        step(3'b101, 3'b000, 1'b0);
        chk("R3 even decode wins next", in_use, 3'b001);
        step(3'b001, 3'b100, 1'b0);
        chk("R6 owner kept under freeze", in_use, 3'b001);
        chk("R8 ack rises", lock_ack, 3'b100);
        step(3'b000, 3'b100, 1'b0);
        chk("R6 release held off", in_use, 3'b001);
        step(3'b000, 3'b000, 1'b0);
        chk("R6 release after freeze clears", in_use, 3'b000);
        chk("R8 ack falls", lock_ack, 3'b000);
        step(3'b000, 3'b010, 1'b0);
        step(3'b111, 3'b010, 1'b0);
        chk("R7 requests ignored while frozen", in_use, 3'b000);
        step(3'b111, 3'b000, 1'b0);
        chk("R7 grant after freeze clears", in_use, 3'b001);
        step(3'b001, 3'b001, 1'b1);
        chk("R9 unit reset overrides freeze", in_use, 3'b000);
        chk("R9 ack unaffected by unit reset", lock_ack, 3'b001);
        step(3'b001, 3'b000, 1'b0);
        chk("R9 regrant after unit reset", in_use, 3'b001);

        for (int k = 0; k < 3000; k++) begin
            logic [2:0] r, f;
            logic u;
            r = 3'($urandom_range(0, 7));
            f = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
            u = ($urandom_range(0, 49) == 0);
            if ($urandom_range(0, 3) == 0) f = force_lock;
            step(r, f, u);
            chk("R10/R2 random in_use", in_use, use_of(m_held, m_who));
            chk("R8 random lock_ack", lock_ack, m_ack);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule